// File: doc/BRIEF.md
# Debug Link Switching Sequence Generator

This block drives the special waveforms that a debug probe must put on the shared data/mode line of a combined debug port. These waveforms reset a serial-wire link or move the port between its JTAG, serial-wire and low-power dormant states. The block owns a single output line and the enable for that line. An external clock-enable pulse, `tick`, marks each debug clock edge on which the target samples the line.

A caller places a 3-bit code on `cmd` and raises `start` for one clock while the block is idle. The block latches the code and drives the first bit of the pattern at once. It presents one bit per `tick`, least significant bit first within every field. One clock after the `tick` that closes the last bit, it pulses `done` and releases the line low. Each pattern is built from fixed phases: runs of ones, runs of zeros, 16-bit or 31-bit switching codes, a 128-bit selection alert and an activation code. Each pattern has a fixed total length.

Top module: `swj_seq_gen`

## Requirements
- R1: After a synchronous reset, `line_out`, `line_oe`, `busy`, `done` and `err` are all 0.
- R2: Code 0 (link reset) sends 56 ones and then 8 zeros, 64 bits in total.
- R3: Code 1 (JTAG to serial wire) sends 56 ones, then 16'hE79E LSB first, then 56 ones, then 8 zeros, 136 bits in total.
- R4: Code 2 (serial wire to JTAG) sends 56 ones, then 16'hE73C LSB first, then 8 ones, 80 bits in total.
- R5: Code 3 (serial wire to dormant) sends 56 ones, then 16'hE3BC LSB first, 72 bits in total.
- R6: Code 4 (dormant to serial wire) sends 8 ones, the selection alert, 4 zeros, 8'h1A LSB first, 68 ones and then 8 zeros, 224 bits in total.
- R7: Code 5 (JTAG to dormant) sends 9 ones, then the 31 low bits of 32'h33BBBBBA LSB first, 40 bits in total.
- R8: Code 6 (dormant to JTAG) sends 8 ones, the selection alert, and then 24 zeros, 160 bits in total.
- R9: The selection alert is 128 bits. It is sent as the bytes 92, F3, 09, 62, 95, 2D, 85, 86, E9, AF, DD, E3, A2, 0E, BC, 19 (hex), in that order, each byte LSB first.
- R10: An accepted `start` sets `busy` and `line_oe` on the next clock and puts bit 0 on `line_out`. Bit k stays on the line until the clock that samples the (k+1)-th `tick`. The line never changes on clocks without `tick`, and `line_oe` stays 1 for the whole pattern.
- R11: `done` is 1 for exactly one clock, the one after the clock that samples the `tick` of the last bit. At that point `busy`, `line_oe` and `line_out` are all 0.
- R12: A `start` while `busy` is ignored. The running pattern keeps its bits and length, and `err` stays 0.
- R13: Code 7 with `start` while idle raises `err` for exactly one clock. It sets neither `busy` nor `line_oe`, and later ticks leave the line quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Debug clock enable; one pulse per transmitted bit |
| start | input | 1 | Request to send the pattern selected by `cmd` |
| cmd | input | 3 | Pattern selector, codes 0 to 6; 7 is unsupported |
| line_out | output | 1 | Data/mode line level |
| line_oe | output | 1 | Output enable for the line |
| busy | output | 1 | A pattern is being sent |
| done | output | 1 | One-clock pulse after the last bit |
| err | output | 1 | One-clock pulse on an unsupported code |

## Verification
The hardest situations to reach from the ports are two. One is a second request that lands in the middle of a long pattern. The other is a gap between ticks that happens to fall on a phase boundary. The stimulus raises `start` with a different valid code, and also with the unsupported code, part way through a pattern and between ticks. It inserts idle clocks without `tick` at regular bit intervals, so some gaps fall where the pattern moves from one phase to the next. The bench captures every bit that is presented, compares the captured stream with a pattern it builds phase by phase from the requirements, and then checks the clock that carries `done`.

// File: rtl/swj_seq_pkg.sv
package swj_seq_pkg;

    localparam int SEQ_IDX_W = 8;

    typedef enum logic [2:0] {
        SEQ_LINK_RST = 3'd0,
        SEQ_J2S      = 3'd1,
        SEQ_S2J      = 3'd2,
        SEQ_S2D      = 3'd3,
        SEQ_D2S      = 3'd4,
        SEQ_J2D      = 3'd5,
        SEQ_D2J      = 3'd6,
        SEQ_NONE     = 3'd7
    } seq_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // bit i of each constant is the i-th bit on the line
    localparam logic [127:0] ALERT_BITS =
        128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
    localparam logic [15:0] SW_J2S  = 16'hE79E;
    localparam logic [15:0] SW_S2J  = 16'hE73C;
    localparam logic [15:0] SW_S2D  = 16'hE3BC;
    localparam logic [31:0] SW_J2D  = 32'h33BBBBBA;
    localparam logic [7:0]  ACT_SW  = 8'h1A;

    function automatic logic [SEQ_IDX_W-1:0] seq_last(seq_code_e c);
        case (c)
            SEQ_LINK_RST: return 8'd63;
            SEQ_J2S:      return 8'd135;
            SEQ_S2J:      return 8'd79;
            SEQ_S2D:      return 8'd71;
            SEQ_D2S:      return 8'd223;
            SEQ_J2D:      return 8'd39;
            SEQ_D2J:      return 8'd159;
            default:      return 8'd0;
        endcase
    endfunction

    function automatic logic seq_known(logic [2:0] c);
        return c != SEQ_NONE;
    endfunction

endpackage

// File: rtl/swj_seq_bitgen.sv
module swj_seq_bitgen
    import swj_seq_pkg::*;
(
    input  seq_code_e              code,
    input  logic [SEQ_IDX_W-1:0]   idx,
    output logic                   bit_o
);
    always_comb begin
        bit_o = 1'b0;
        case (code)
            SEQ_LINK_RST: bit_o = (idx < 8'd56);
            SEQ_J2S: begin
                if (idx < 8'd56)       bit_o = 1'b1;
                else if (idx < 8'd72)  bit_o = SW_J2S[4'(idx - 8'd56)];
                else                   bit_o = (idx < 8'd128);
            end
            SEQ_S2J: begin
                if (idx >= 8'd56 && idx < 8'd72) bit_o = SW_S2J[4'(idx - 8'd56)];
                else                             bit_o = 1'b1;
            end
            SEQ_S2D: begin
                if (idx < 8'd56) bit_o = 1'b1;
                else             bit_o = SW_S2D[4'(idx - 8'd56)];
            end
            SEQ_D2S: begin
                if (idx < 8'd8)        bit_o = 1'b1;
                else if (idx < 8'd136) bit_o = ALERT_BITS[7'(idx - 8'd8)];
                else if (idx < 8'd140) bit_o = 1'b0;
                else if (idx < 8'd148) bit_o = ACT_SW[3'(idx - 8'd140)];
                else                   bit_o = (idx < 8'd216);
            end
            SEQ_J2D: begin
                if (idx < 8'd9) bit_o = 1'b1;
                else            bit_o = SW_J2D[5'(idx - 8'd9)];
            end
            SEQ_D2J: begin
                if (idx < 8'd8)        bit_o = 1'b1;
                else if (idx < 8'd136) bit_o = ALERT_BITS[7'(idx - 8'd8)];
                else                   bit_o = 1'b0;
            end
            default: bit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/swj_seq_ctrl.sv
module swj_seq_ctrl
    import swj_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  start,
    input  logic [2:0]            cmd,
    output logic                  accept,
    output logic                  advance,
    output logic                  finish,
    output seq_code_e             gen_code,
    output logic [SEQ_IDX_W-1:0]  gen_idx,
    output logic                  busy,
    output logic                  done,
    output logic                  err
);
    seq_state_e             state;
    seq_code_e              cur_code;
    logic [SEQ_IDX_W-1:0]   idx;
    logic                   at_last;
    logic                   reject;

    assign at_last = (idx == seq_last(cur_code));
    assign accept  = (state == ST_IDLE) && start && seq_known(cmd);
    assign reject  = (state == ST_IDLE) && start && !seq_known(cmd);
    assign advance = (state == ST_RUN) && tick && !at_last;
    assign finish  = (state == ST_RUN) && tick && at_last;
    assign busy    = (state == ST_RUN);

    // idle: look up bit 0 of the requested code; running: the next bit
    assign gen_code = (state == ST_RUN) ? cur_code : seq_code_e'(cmd);
    assign gen_idx  = (state == ST_RUN) ? idx + 8'd1 : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_code <= SEQ_LINK_RST;
            idx      <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= finish;
            err  <= reject;
            if (accept) begin
                state    <= ST_RUN;
                cur_code <= seq_code_e'(cmd);
                idx      <= '0;
            end else if (advance) begin
                idx <= idx + 8'd1;
            end else if (finish) begin
                state <= ST_IDLE;
                idx   <= '0;
            end
        end
    end

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(state) == ST_RUN) && (state == ST_IDLE)); // R11
    AST_ERR_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
        err |-> (state == ST_IDLE) && ($past(state) == ST_IDLE)); // R13
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_RUN) |-> $stable(cur_code)); // R12
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (idx <= seq_last(cur_code))); // R10
endmodule

// File: rtl/swj_seq_drv.sv
module swj_seq_drv (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic advance,
    input  logic finish,
    input  logic gen_bit,
    output logic line_out,
    output logic line_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line_out <= 1'b0;
            line_oe  <= 1'b0;
        end else if (accept) begin
            line_out <= gen_bit;
            line_oe  <= 1'b1;
        end else if (advance) begin
            line_out <= gen_bit;
        end else if (finish) begin
            line_out <= 1'b0;
            line_oe  <= 1'b0;
        end
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (line_oe && $past(line_oe) && !$past(advance) && !$past(finish))
        |-> $stable(line_out)); // R10
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> !line_out); // R11
endmodule

// File: rtl/swj_seq_gen.sv
module swj_seq_gen
    import swj_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start,
    input  logic [2:0] cmd,
    output logic       line_out,
    output logic       line_oe,
    output logic       busy,
    output logic       done,
    output logic       err
);
    logic                  accept;
    logic                  advance;
    logic                  finish;
    logic                  gen_bit;
    seq_code_e             gen_code;
    logic [SEQ_IDX_W-1:0]  gen_idx;

    swj_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .start    (start),
        .cmd      (cmd),
        .accept   (accept),
        .advance  (advance),
        .finish   (finish),
        .gen_code (gen_code),
        .gen_idx  (gen_idx),
        .busy     (busy),
        .done     (done),
        .err      (err)
    );

    swj_seq_bitgen u_bitgen (
        .code  (gen_code),
        .idx   (gen_idx),
        .bit_o (gen_bit)
    );

    swj_seq_drv u_drv (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .advance  (advance),
        .finish   (finish),
        .gen_bit  (gen_bit),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    AST_OE_TRACKS_BUSY: assert property (@(posedge clk) disable iff (rst)
        line_oe == busy); // R10
    AST_NO_DONE_AND_ERR: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R13
endmodule

// File: tb/tb_swj_seq_gen.sv
`timescale 1ns/1ps
module tb_swj_seq_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic [2:0] cmd = 3'd0;
    logic       line_out, line_oe, busy, done, err;

    int n_tests = 0;
    int n_fail  = 0;

    logic [255:0] exp_v;
    int           n_exp;
    logic [255:0] cap;
    int r_oe_bad, r_hold_bad, r_early, r_err_seen;
    logic r_done, r_oe_end, r_line_end, r_busy_end, r_done_next;

    always #2.5 clk = ~clk;

    swj_seq_gen dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .cmd(cmd),
        .line_out(line_out), .line_oe(line_oe), .busy(busy),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic clear_exp();
        exp_v = '0;
        n_exp = 0;
    endtask

    task automatic push_run(input bit level, input int nb);
        for (int i = 0; i < nb; i++) begin
            exp_v[n_exp] = level;
            n_exp++;
        end
    endtask

    task automatic push_val(input logic [31:0] v, input int nb);
        for (int i = 0; i < nb; i++) begin
            exp_v[n_exp] = v[i];
            n_exp++;
        end
    endtask

    task automatic push_alert();
        logic [7:0] al [16];
        al = '{8'h92, 8'hF3, 8'h09, 8'h62, 8'h95, 8'h2D, 8'h85, 8'h86,
               8'hE9, 8'hAF, 8'hDD, 8'hE3, 8'hA2, 8'h0E, 8'hBC, 8'h19};
        for (int b = 0; b < 16; b++) push_val({24'd0, al[b]}, 8);
    endtask

    task automatic run_seq(input logic [2:0] code, input bit gaps, input bit intrude);
        r_oe_bad = 0; r_hold_bad = 0; r_early = 0; r_err_seen = 0;
        cap = '0;
        @(negedge clk); start = 1'b1; cmd = code;
        @(negedge clk); start = 1'b0; cmd = 3'd0;
        for (int k = 0; k < n_exp; k++) begin
            if (line_oe !== 1'b1 || busy !== 1'b1) r_oe_bad++;
            if (err) r_err_seen++;
            cap[k] = line_out;
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk);
                if (line_out !== cap[k]) r_hold_bad++;
            end
            if (intrude && (k == 10 || k == 20)) begin
                start = 1'b1;
                cmd = (k == 10) ? ((code == 3'd0) ? 3'd4 : 3'd0) : 3'd7;
                @(negedge clk); start = 1'b0; cmd = 3'd0;
                if (err) r_err_seen++;
                if (line_out !== cap[k]) r_hold_bad++;
                @(negedge clk);
                if (err) r_err_seen++;
            end
            tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (k < n_exp - 1 && done) r_early++;
        end
        r_done = done; r_oe_end = line_oe; r_line_end = line_out; r_busy_end = busy;
        @(negedge clk);
        r_done_next = done;
    endtask

    task automatic judge(input string req, input bit gaps);
        int first = -1;
        for (int k = 0; k < n_exp; k++)
            if (first < 0 && cap[k] !== exp_v[k]) first = k;
        check(first < 0, req, $sformatf("bit stream, first mismatch at %0d", first),
              (first < 0) ? 0 : cap[first], (first < 0) ? 0 : exp_v[first]);
        check(r_oe_bad == 0, "R10", {req, " enable held over pattern"}, r_oe_bad, 0);
        if (gaps) check(r_hold_bad == 0, "R10", {req, " line stable without tick"}, r_hold_bad, 0);
        check(r_done === 1'b1 && r_early == 0 && r_done_next === 1'b0, "R11",
              {req, " done pulse timing"}, {r_early[7:0], 2'b00, r_done, r_done_next}, 4'b0010);
        check(!r_oe_end && !r_line_end && !r_busy_end, "R11", {req, " line released low"},
              {r_busy_end, r_oe_end, r_line_end}, 0);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({line_out, line_oe, busy, done, err} === 5'b0, "R1", "outputs in reset",
              {line_out, line_oe, busy, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({line_out, line_oe, busy, done, err} === 5'b0, "R1", "outputs after reset",
              {line_out, line_oe, busy, done, err}, 0);
    endtask

    task automatic test_link_reset();
        clear_exp(); push_run(1, 56); push_run(0, 8);
        check(n_exp == 64, "R2", "model length", n_exp, 64);
        run_seq(3'd0, 1'b0, 1'b0); judge("R2", 1'b0);
    endtask

    task automatic test_j2s();
        clear_exp(); push_run(1, 56); push_val(32'h0000E79E, 16);
        push_run(1, 56); push_run(0, 8);
        run_seq(3'd1, 1'b1, 1'b0); judge("R3", 1'b1);
    endtask

    task automatic test_s2j();
        clear_exp(); push_run(1, 56); push_val(32'h0000E73C, 16); push_run(1, 8);
        run_seq(3'd2, 1'b0, 1'b1); judge("R4", 1'b0);
        check(r_err_seen == 0, "R12", "no err while busy", r_err_seen, 0);
    endtask

    task automatic test_s2d();
        clear_exp(); push_run(1, 56); push_val(32'h0000E3BC, 16);
        run_seq(3'd3, 1'b1, 1'b0); judge("R5", 1'b1);
    endtask

    task automatic test_d2s();
        clear_exp(); push_run(1, 8); push_alert(); push_run(0, 4);
        push_val(32'h1A, 8); push_run(1, 68); push_run(0, 8);
        check(n_exp == 224, "R6", "model length", n_exp, 224);
        run_seq(3'd4, 1'b1, 1'b0); judge("R6", 1'b1);
        check(cap[8 +: 128] === exp_v[8 +: 128], "R9", "alert inside code 4",
              cap[8 +: 64], exp_v[8 +: 64]);
    endtask

    task automatic test_j2d();
        clear_exp(); push_run(1, 9); push_val(32'h33BBBBBA, 31);
        run_seq(3'd5, 1'b0, 1'b0); judge("R7", 1'b0);
    endtask

    task automatic test_d2j();
        clear_exp(); push_run(1, 8); push_alert(); push_run(0, 24);
        run_seq(3'd6, 1'b1, 1'b1); judge("R8", 1'b1);
        check(r_err_seen == 0, "R12", "no err while busy", r_err_seen, 0);
        check(cap[8 +: 128] === exp_v[8 +: 128], "R9", "alert inside code 6",
              cap[72 +: 64], exp_v[72 +: 64]);
    endtask

    task automatic test_link_intrude();
        clear_exp(); push_run(1, 56); push_run(0, 8);
        run_seq(3'd0, 1'b0, 1'b1); judge("R12", 1'b0);
        check(r_err_seen == 0, "R12", "no err while busy", r_err_seen, 0);
    endtask

    task automatic test_bad_code();
        int seen_oe = 0;
        @(negedge clk); start = 1'b1; cmd = 3'd7;
        @(negedge clk); start = 1'b0; cmd = 3'd0;
        check(err === 1'b1 && busy === 1'b0 && line_oe === 1'b0, "R13", "err pulse, no run",
              {err, busy, line_oe}, 3'b100);
        @(negedge clk);
        check(err === 1'b0, "R13", "err lasts one clock", err, 0);
        for (int i = 0; i < 6; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            if (line_oe || line_out || busy || done) seen_oe++;
        end
        check(seen_oe == 0, "R13", "line quiet after bad code", seen_oe, 0);
    endtask

    initial begin
        test_reset();
        test_link_reset();
        test_j2s();
        test_s2j();
        test_s2d();
        test_d2s();
        test_j2d();
        test_d2j();
        test_link_intrude();
        test_bad_code();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule